// File: doc/BRIEF.md
# Trigger-Latency Sample Pipeline with Accept Derandomizer

The block records one 9-bit raw sample per bunch crossing into a circular pipeline. Each sample is 7 data bits and 2 capacitor-ID bits, stored unconverted. The pipeline keeps a crossing long enough for the first-level trigger to decide on it. When an accept strobe arrives, the block finds the crossing that lies a configured number of crossings in the past. It then copies that crossing and the following ones, a fixed window of consecutive samples, into a derandomizing FIFO. The readout side empties the FIFO one sample per pop, at its own rate.

Accepts that arrive while a window is being copied wait in a short queue of window start addresses. An accept is refused when the FIFO could not hold its window, counting space already promised to queued windows. It is also refused when the queue has no free slot. Each refusal sets a sticky flag and advances a saturating counter. With the default parameters the pipeline is 200 cells deep, a window is 10 samples, and the FIFO holds 15 windows (150 samples).

The copy is run by a state machine with two states. `ST_IDLE` waits for a queued window. `ST_COPY` moves one sample per cycle. The state machine has four transitions:
- **start**: `ST_IDLE` to `ST_COPY` when the queue is not empty.
- **advance**: `ST_COPY` to `ST_COPY` while the window is unfinished.
- **chain**: `ST_COPY` to `ST_COPY` on the last sample when another window is queued.
- **finish**: `ST_COPY` to `ST_IDLE` on the last sample when the queue is empty.

Top module: `accept_window_buffer`

## Requirements
- R1: After reset, `fifo_level` is 0, `fifo_empty` is 1, `fifo_full` is 0, `ovf_flag` is 0 and `ovf_count` is 0.
- R2: Every clock edge after reset writes `smp_in` into the pipeline as the next crossing. An accept is sampled at the edge that writes crossing w, and `trig_delay` is D. That accept delivers the samples of crossings w-D through w-D+9 to the FIFO in that order. `rd_sof` is 1 on the first sample of the window and 0 on the other nine. This holds across the wrap of the pipeline.
- R3: Take an accepted strobe sampled at edge E while the FIFO is empty and idle. `fifo_level` is still 0 after E+1. It becomes 1 after E+2 and reaches 10 after E+11.
- R4: Accepts that arrive while a window is being copied are queued, up to 4 waiting. Their windows follow each other with no gap and in the order the accepts arrived.
- R5: An accept is dropped in one case: the current level, plus the samples still owed to queued and running windows, plus 10 would exceed 150. A drop sets `ovf_flag`, which stays 1 until reset, and advances `ovf_count`. The FIFO never receives a sample while full. Its stored contents are not changed by a dropped accept.
- R6: An accept that arrives while 4 windows are already waiting in the queue is dropped. It is counted and flagged as in R5.
- R7: A pop while the FIFO holds data removes the oldest sample. A pop while the FIFO is empty is ignored, and the level stays 0.
- R8: `fifo_full` is 1 exactly when `fifo_level` is 150, and `fifo_empty` is 1 exactly when `fifo_level` is 0.
- R9: `ovf_count` saturates at 255 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | 9 | Raw sample of the current crossing |
| trig_delay | input | 8 | Crossings between the triggered crossing and the accept |
| accept | input | 1 | First-level accept strobe |
| pop | input | 1 | Readout removes the FIFO head sample |
| rd_data | output | 9 | FIFO head sample |
| rd_sof | output | 1 | Head sample is the first of its window |
| fifo_level | output | 8 | Samples held in the FIFO |
| fifo_full | output | 1 | FIFO holds 150 samples |
| fifo_empty | output | 1 | FIFO holds no sample |
| ovf_flag | output | 1 | Sticky: at least one accept was dropped |
| ovf_count | output | 8 | Saturating count of dropped accepts |

## Verification
The assertions assume that `trig_delay` lies between 1 and 150. This keeps every window read from the pipeline before its cells are overwritten, even after waiting behind four queued windows. They also assume that `trig_delay` is changed only while no window is queued or being copied. The bench changes the delay only after the previous windows have landed. It issues accepts only after at least `trig_delay` crossings have passed since reset, and it drives pop freely, including onto an empty FIFO.

// File: rtl/awb_pkg.sv
package awb_pkg;

    // Copy engine states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_COPY = 1'b1
    } cap_state_e;

endpackage

// File: rtl/awb_ring.sv
// Circular sample store: one write per edge, asynchronous read port
module awb_ring #(
    parameter  int W     = 9,
    parameter  int DEPTH = 200,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     wr_data,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [W-1:0]     rd_data,
    output logic [PTR_W-1:0] wr_ptr
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (wr_ptr == PTR_W'(DEPTH - 1))
            wr_ptr <= '0;
        else
            wr_ptr <= wr_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst_n)
            cells[wr_ptr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/awb_pend.sv
// Small queue of window start addresses waiting for the copy engine
module awb_pend #(
    parameter  int W     = 8,
    parameter  int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    logic [W-1:0]     slots [DEPTH];
    logic [IDX_W-1:0] wr_i, rd_i;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_i <= '0;
            rd_i <= '0;
            cnt  <= '0;
        end else begin
            if (push)
                wr_i <= (wr_i == IDX_W'(DEPTH - 1)) ? '0 : wr_i + 1'b1;
            if (pop)
                rd_i <= (rd_i == IDX_W'(DEPTH - 1)) ? '0 : rd_i + 1'b1;
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push)
            slots[wr_i] <= din;
    end

    assign head  = slots[rd_i];
    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
endmodule

// File: rtl/awb_fifo.sv
// Derandomizing sample FIFO with show-ahead head
module awb_fifo #(
    parameter  int W     = 10,
    parameter  int DEPTH = 150,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level
);
    logic [W-1:0]     store [DEPTH];
    logic [IDX_W-1:0] wr_i, rd_i;
    logic             pop_eff;

    assign pop_eff = pop && (level != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_i  <= '0;
            rd_i  <= '0;
            level <= '0;
        end else begin
            if (push)
                wr_i <= (wr_i == IDX_W'(DEPTH - 1)) ? '0 : wr_i + 1'b1;
            if (pop_eff)
                rd_i <= (rd_i == IDX_W'(DEPTH - 1)) ? '0 : rd_i + 1'b1;
            level <= level + LVL_W'(push) - LVL_W'(pop_eff);
        end
    end

    always_ff @(posedge clk) begin
        if (push)
            store[wr_i] <= din;
    end

    assign dout = store[rd_i];
endmodule

// File: rtl/accept_window_buffer.sv
module accept_window_buffer
    import awb_pkg::*;
#(
    parameter  int SMP_W      = 9,
    parameter  int PIPE_DEPTH = 200,
    parameter  int WIN_LEN    = 10,
    parameter  int EVT_DEPTH  = 15,
    parameter  int PEND_DEPTH = 4,
    parameter  int OVF_W      = 8,
    localparam int FIFO_DEPTH = WIN_LEN * EVT_DEPTH,
    localparam int PTR_W      = $clog2(PIPE_DEPTH),
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp_in,
    input  logic [PTR_W-1:0] trig_delay,
    input  logic             accept,
    input  logic             pop,
    output logic [SMP_W-1:0] rd_data,
    output logic             rd_sof,
    output logic [LVL_W-1:0] fifo_level,
    output logic             fifo_full,
    output logic             fifo_empty,
    output logic             ovf_flag,
    output logic [OVF_W-1:0] ovf_count
);
    localparam int WIN_W = $clog2(WIN_LEN);
    localparam logic [WIN_W-1:0] K_LAST = WIN_W'(WIN_LEN - 1);

    cap_state_e       state, nxt_state;
    logic [WIN_W-1:0] k_q;
    logic [PTR_W-1:0] wr_ptr, base_now, cur_base, rd_addr, pq_head;
    logic [PTR_W:0]   addr_sum;
    logic [SMP_W-1:0] ring_q;
    logic             pq_pop, pq_full, pq_empty;
    logic             ff_push, ff_sof;
    logic [LVL_W-1:0] rsv_q;
    logic [LVL_W:0]   need;
    logic             acc_ok, acc_drop;

    // Pipeline of raw samples
    awb_ring #(.W(SMP_W), .DEPTH(PIPE_DEPTH)) i_ring (
        .clk(clk), .rst_n(rst_n), .wr_data(smp_in),
        .rd_addr(rd_addr), .rd_data(ring_q), .wr_ptr(wr_ptr)
    );

    // Start cell of the triggered crossing, modulo the ring size
    always_comb begin
        if (wr_ptr >= trig_delay)
            base_now = wr_ptr - trig_delay;
        else
            base_now = wr_ptr + PTR_W'(PIPE_DEPTH) - trig_delay;
    end

    // Admission: promised space plus this window must fit
    assign need     = (LVL_W+1)'(fifo_level) + (LVL_W+1)'(rsv_q) + (LVL_W+1)'(WIN_LEN);
    assign acc_ok   = accept && !pq_full && (need <= (LVL_W+1)'(FIFO_DEPTH));
    assign acc_drop = accept && !acc_ok;

    awb_pend #(.W(PTR_W), .DEPTH(PEND_DEPTH)) i_pend (
        .clk(clk), .rst_n(rst_n), .push(acc_ok), .din(base_now),
        .pop(pq_pop), .head(pq_head), .full(pq_full), .empty(pq_empty)
    );

    // Next state and copy-engine outputs
    always_comb begin
        nxt_state = state;
        pq_pop    = 1'b0;
        ff_push   = 1'b0;
        ff_sof    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!pq_empty) begin
                    pq_pop    = 1'b1;
                    nxt_state = ST_COPY;
                end
            end
            ST_COPY: begin
                ff_push = 1'b1;
                ff_sof  = (k_q == '0);
                if (k_q == K_LAST) begin
                    if (!pq_empty)
                        pq_pop = 1'b1;
                    else
                        nxt_state = ST_IDLE;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State register with window position and start cell
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            k_q      <= '0;
            cur_base <= '0;
        end else begin
            state <= nxt_state;
            if (pq_pop) begin
                cur_base <= pq_head;
                k_q      <= '0;
            end else if (state == ST_COPY) begin
                k_q <= k_q + 1'b1;
            end
        end
    end

    assign addr_sum = {1'b0, cur_base} + (PTR_W+1)'(k_q);
    assign rd_addr  = (addr_sum >= (PTR_W+1)'(PIPE_DEPTH))
                    ? PTR_W'(addr_sum - (PTR_W+1)'(PIPE_DEPTH))
                    : addr_sum[PTR_W-1:0];

    awb_fifo #(.W(SMP_W + 1), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(ff_push), .din({ff_sof, ring_q}),
        .pop(pop), .dout({rd_sof, rd_data}), .level(fifo_level)
    );

    // Samples promised to admitted windows but not yet written
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rsv_q <= '0;
        else
            rsv_q <= rsv_q + (acc_ok ? LVL_W'(WIN_LEN) : '0) - LVL_W'(ff_push);
    end

    // Drop reporting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag  <= 1'b0;
            ovf_count <= '0;
        end else if (acc_drop) begin
            ovf_flag <= 1'b1;
            if (ovf_count != '1)
                ovf_count <= ovf_count + 1'b1;
        end
    end

    assign fifo_full  = (fifo_level == LVL_W'(FIFO_DEPTH));
    assign fifo_empty = (fifo_level == '0);
endmodule

// File: rtl/awb_checker.sv
module awb_checker #(
    parameter int FIFO_DEPTH = 150,
    parameter int LVL_W      = 8,
    parameter int OVF_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             accept,
    input logic             pop,
    input logic             push,
    input logic [LVL_W-1:0] fifo_level,
    input logic             fifo_full,
    input logic             fifo_empty,
    input logic             ovf_flag,
    input logic [OVF_W-1:0] ovf_count
);
    p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(FIFO_DEPTH));

    p_no_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !fifo_full);

    p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && fifo_empty && !push) |=> fifo_empty);

    p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(fifo_level));

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    p_flag_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag == (ovf_count != '0));

    p_drop_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fifo_full) |=>
            ((ovf_count == $past(ovf_count) + 1'b1) ||
             (($past(ovf_count) == '1) && (ovf_count == '1))));
endmodule

bind accept_window_buffer awb_checker #(
    .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .OVF_W(OVF_W)
) i_awb_checker (
    .clk(clk), .rst_n(rst_n), .accept(accept), .pop(pop), .push(ff_push),
    .fifo_level(fifo_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .ovf_flag(ovf_flag), .ovf_count(ovf_count)
);

// File: tb/test_accept_window_buffer.sv
module test_accept_window_buffer;
    localparam int WIN    = 10;
    localparam int FDEPTH = 150;
    localparam int PTR_W  = 8;
    localparam int LVL_W  = 8;
    localparam int OVF_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [8:0]       smp_in = '0;
    logic [PTR_W-1:0] trig_delay = 8'd20;
    logic             accept = 1'b0;
    logic             pop = 1'b0;
    logic [8:0]       rd_data;
    logic             rd_sof;
    logic [LVL_W-1:0] fifo_level;
    logic             fifo_full, fifo_empty, ovf_flag;
    logic [OVF_W-1:0] ovf_count;

    int xn = 0;
    int nchk = 0;
    int nerr = 0;
    int exp_ovf = 0;
    int exp_q[$];

    accept_window_buffer i_accept_window_buffer (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .trig_delay(trig_delay),
        .accept(accept), .pop(pop), .rd_data(rd_data), .rd_sof(rd_sof),
        .fifo_level(fifo_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .ovf_flag(ovf_flag), .ovf_count(ovf_count)
    );

    always #2 clk = ~clk;

    function automatic logic [8:0] patt(int n);
        return 9'((n * 37 + 11) % 512);
    endfunction

    // Crossing number that the next edge writes
    always @(posedge clk) if (rst_n) xn <= xn + 1;
    always @(negedge clk) smp_in <= patt(xn);

    task automatic check(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(bit expect_ok);
        accept = 1'b1;
        if (expect_ok) exp_q.push_back(xn - int'(trig_delay));
        else if (exp_ovf < 255) exp_ovf++;
        @(negedge clk);
        accept = 1'b0;
    endtask

    task automatic drain_check(string req);
        while (exp_q.size() > 0) begin
            int base = exp_q.pop_front();
            int bad_act = 0, bad_exp = 0;
            bit ok = 1'b1;
            for (int k = 0; k < WIN; k++) begin
                if (fifo_empty) begin
                    if (ok) begin bad_act = -1; bad_exp = int'(patt(base + k)); end
                    ok = 1'b0;
                    break;
                end
                if (ok && (rd_data != patt(base + k) || rd_sof != (k == 0))) begin
                    ok = 1'b0;
                    bad_act = int'({rd_sof, rd_data});
                    bad_exp = int'({(k == 0), patt(base + k)});
                end
                pop = 1'b1;
                @(negedge clk);
                pop = 1'b0;
            end
            check(ok, {req, " window content"}, bad_act, bad_exp);
        end
        check(fifo_empty, {req, " empty after drain"}, int'(fifo_level), 0);
    endtask

    task automatic t_reset();
        check(fifo_level == 0, "R1 level", int'(fifo_level), 0);
        check(fifo_empty,      "R1 empty", int'(fifo_empty), 1);
        check(!fifo_full,      "R1 full",  int'(fifo_full), 0);
        check(!ovf_flag && ovf_count == 0, "R1 overflow", int'(ovf_count), 0);
    endtask

    task automatic t_pop_empty();
        pop = 1'b1;
        wait_n(3);
        pop = 1'b0;
        wait_n(1);
        check(fifo_level == 0 && fifo_empty, "R7 pop on empty", int'(fifo_level), 0);
    endtask

    task automatic t_single();
        trig_delay = 8'd20;
        wait_n(30);
        fire(1'b1);
        wait_n(1);
        check(fifo_level == 0, "R3 level one edge after accept", int'(fifo_level), 0);
        wait_n(1);
        check(fifo_level == 1, "R3 first sample lands", int'(fifo_level), 1);
        wait_n(9);
        check(fifo_level == 10, "R3 window complete", int'(fifo_level), 10);
        drain_check("R2 single");
    endtask

    task automatic t_delay_edges();
        trig_delay = 8'd1;
        fire(1'b1);
        wait_n(15);
        trig_delay = 8'd150;
        wait_n(160);
        fire(1'b1);
        wait_n(15);
        check(fifo_level == 20, "R2 two windows stored", int'(fifo_level), 20);
        drain_check("R2 delay limits");
    endtask

    task automatic t_queue();
        trig_delay = 8'd40;
        fire(1'b1);
        fire(1'b1);
        fire(1'b1);
        wait_n(40);
        check(fifo_level == 30, "R4 queued windows stored", int'(fifo_level), 30);
        drain_check("R4 order");
    endtask

    task automatic t_pend_full();
        for (int i = 0; i < 5; i++) fire(1'b1);
        fire(1'b0);
        wait_n(1);
        check(ovf_flag && int'(ovf_count) == exp_ovf, "R6 queue-full drop",
              int'(ovf_count), exp_ovf);
        wait_n(60);
        check(fifo_level == 50, "R6 kept windows", int'(fifo_level), 50);
        drain_check("R6 kept data");
    endtask

    task automatic t_fill();
        trig_delay = 8'd30;
        for (int i = 0; i < 14; i++) begin
            fire(1'b1);
            wait_n(11);
        end
        check(fifo_level == 140, "R8 level before last window", int'(fifo_level), 140);
        fire(1'b1);
        fire(1'b0);
        wait_n(12);
        check(fifo_level == 150, "R5 reservation drop keeps level", int'(fifo_level), 150);
        check(fifo_full && !fifo_empty, "R8 full flag", int'(fifo_full), 1);
        check(int'(ovf_count) == exp_ovf, "R5 reservation drop counted",
              int'(ovf_count), exp_ovf);
        fire(1'b0);
        wait_n(1);
        check(fifo_level == 150 && int'(ovf_count) == exp_ovf, "R5 drop while full",
              int'(ovf_count), exp_ovf);
        accept = 1'b1;
        wait_n(260);
        accept = 1'b0;
        exp_ovf = 255;
        wait_n(1);
        check(int'(ovf_count) == exp_ovf, "R9 saturation", int'(ovf_count), exp_ovf);
        check(ovf_flag, "R5 flag sticky", int'(ovf_flag), 1);
        drain_check("R5 contents after drops");
        check(!fifo_full, "R8 not full after drain", int'(fifo_full), 0);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_pop_empty();
        t_single();
        t_delay_edges();
        t_queue();
        t_pend_full();
        t_fill();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule